// File: doc/BRIEF.md
# SPI-Fed Transmit Byte Buffer

This block collects payload bytes pushed by an SPI master (mode 0: clock idles low, data sampled on the rising clock edge, active-low chip select) and queues them in a first-in first-out byte store. A downstream transmit sequencer drains the queue one byte per pop request. The SPI pins are synchronised into the system clock domain and oversampled, so the system clock must run at least four times faster than the serial clock.

The producer watches a transmit-ready output. It is a low-water-mark indication, not a "not full" flag: it stays high while the store holds at most one eighth of its capacity (512 of 4096 bytes by default). A fill count and a saturating overrun counter are also exposed. A byte that arrives while the store is full is dropped and counted. A clear input from the control logic empties the store and zeroes both counters.

Top module: `spi_payload_buffer`

## Requirements
- R1: Reset is synchronous and active low. After reset the fill count and overrun count read 0, empty is 1 and transmit-ready is 1.
- R2: Bits are assembled MSB first. A byte is stored on its eighth rising SCLK edge while chip select is low. One transaction may carry many consecutive bytes.
- R3: If chip select rises after fewer than eight bits, the partial byte is discarded. The fill count does not change, and the next transaction starts a fresh byte.
- R4: Drained bytes appear in write order. When a pop is accepted at a clock edge, the byte is presented on the read data output from that edge onward.
- R5: The fill count rises by one for each stored byte and falls by one for each accepted pop. A store and a pop at the same edge leave the count unchanged.
- R6: Transmit-ready is 1 while the fill count is at most DEPTH/8 (512 by default) and 0 once it is DEPTH/8+1 or more.
- R7: The store holds DEPTH = 2^ADDR_W bytes (4096 by default) and the fill count never exceeds DEPTH. A byte that arrives when the store is full is dropped, the stored contents are unchanged, and the overrun count increments by one.
- R8: The overrun count saturates at its all-ones value (0xFFFF by default) instead of wrapping.
- R9: A pop while the store is empty is ignored. The fill count stays 0 and the read data output holds its value.
- R10: A clear pulse empties the store, zeroes the fill and overrun counts and raises transmit-ready. Bytes stored after the clear drain first. A byte completing in the same cycle as the clear is dropped.
- R11: SCLK edges while chip select is high store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock (asynchronous) |
| mosi_i | input | 1 | SPI data from master |
| cs_n_i | input | 1 | SPI chip select, active low |
| clear_i | input | 1 | Empty the store and zero the counters |
| pop_i | input | 1 | Drain one byte |
| rd_data_o | output | 8 | Byte taken by the most recent accepted pop |
| empty_o | output | 1 | Store holds no bytes |
| tx_ready_o | output | 1 | Low-water-mark indication for the producer |
| fill_count_o | output | ADDR_W+1 | Number of bytes stored |
| overrun_count_o | output | OVF_W | Saturating count of dropped bytes |

## Verification
The bench drives every boundary of the flag and the counters. It fills the store past the low-water mark and back, which catches an off-by-one threshold or a not-full flag used in its place. It fills the store to capacity and keeps writing until the overrun counter saturates: a design that wraps that counter, or that overwrites the oldest byte, produces wrong counts or wrong drained data. It also cuts a byte short with chip select and pops an empty store; a design that kept stale bits or let the count underflow would misalign later bytes. Finally, it lands a pop in exactly the cycle a byte is stored, so a count update that lets one of the two win shows up as a wrong fill count.

// File: rtl/spb_pkg.sv
// Shared definitions for the SPI payload buffer.
// Assumes byte-wide payload units throughout.
package spb_pkg;
    localparam int BYTE_W  = 8;
    localparam int BITCNT_W = $clog2(BYTE_W);
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spb_sync.sv
// Two-stage synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent (no multi-bit coherence required).
module spb_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two flops per bit to settle metastability before use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/spb_spi_rx.sv
// SPI mode 0 byte assembler running on synchronised pins.
// Detects rising SCLK by oversampling, shifts MSB first, pulses byte_vld_o
// for one clock with the completed byte. Chip select high drops partial bits.
// Assumes clk is at least four times the SCLK rate.
module spb_spi_rx
    import spb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_s,
    input  logic  mosi_s,
    input  logic  cs_n_s,
    output logic  byte_vld_o,
    output byte_t byte_o
);
    logic                sclk_q;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0]   shreg;
    logic                sclk_rise;

    // Rising edge of the synchronised serial clock.
    assign sclk_rise = sclk_s & ~sclk_q;

    // Shift in bits while selected; emit a byte on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q     <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
        end else begin
            sclk_q     <= sclk_s;
            byte_vld_o <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shreg   <= {shreg[BYTE_W-3:0], mosi_s};
                bit_cnt <= bit_cnt + BITCNT_W'(1);
                if (bit_cnt == BITCNT_W'(BYTE_W - 1)) begin
                    byte_vld_o <= 1'b1;
                    byte_o     <= {shreg, mosi_s};
                end
            end
        end
    end
endmodule

// File: rtl/spb_store.sv
// Simple dual-port byte store: one write port, one registered read port.
// Assumes the controller never reads and writes the same live slot.
module spb_store
    import spb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  byte_t             wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output byte_t             rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    // Write port: no reset on the array so it maps to RAM.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    end

    // Read port: output register updates only on an accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= mem[rd_addr_i];
    end
endmodule

// File: rtl/spb_ctrl.sv
// Pointer, fill and overrun control for the byte store.
// Clear has priority over push and pop. Pushes into a full store are
// dropped and counted; pops from an empty store are ignored.
module spb_ctrl #(
    parameter int ADDR_W = 12,
    parameter int OVF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic              pop_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [ADDR_W:0]   fill_o,
    output logic [OVF_W-1:0]  ovf_o,
    output logic              empty_o,
    output logic              ready_o
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C   = CNT_W'(1 << ADDR_W);
    localparam logic [CNT_W-1:0] LOW_WATER = CNT_W'((1 << ADDR_W) / 8);
    localparam logic [OVF_W-1:0] OVF_MAX   = '1;

    logic full;

    // Occupancy decode from the registered count.
    assign full    = (fill_o == DEPTH_C);
    assign empty_o = (fill_o == '0);
    assign ready_o = (fill_o <= LOW_WATER);

    // Accepted operations.
    assign wr_en_o = push_i & ~full & ~clear_i;
    assign rd_en_o = pop_i & ~empty_o & ~clear_i;

    // Write pointer advances on each stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) wr_addr_o <= '0;
        else if (wr_en_o)      wr_addr_o <= wr_addr_o + ADDR_W'(1);
    end

    // Read pointer advances on each accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) rd_addr_o <= '0;
        else if (rd_en_o)      rd_addr_o <= rd_addr_o + ADDR_W'(1);
    end

    // Fill count: up on store, down on pop, unchanged on both.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            fill_o <= '0;
        end else begin
            unique case ({wr_en_o, rd_en_o})
                2'b10:   fill_o <= fill_o + CNT_W'(1);
                2'b01:   fill_o <= fill_o - CNT_W'(1);
                default: fill_o <= fill_o;
            endcase
        end
    end

    // Overrun count: saturating tally of bytes dropped while full.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)                        ovf_o <= '0;
        else if (push_i && full && ovf_o != OVF_MAX)  ovf_o <= ovf_o + OVF_W'(1);
    end
endmodule

// File: rtl/spi_payload_buffer.sv
// SPI-fed transmit byte buffer.
// Synchronises the SPI pins, assembles bytes, queues them for a drain-side
// sequencer and reports fill level, a low-water-mark ready flag and a
// saturating overrun count. Assumes clk >= 4x SCLK.
module spi_payload_buffer
    import spb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OVF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              cs_n_i,
    input  logic              clear_i,
    input  logic              pop_i,
    output logic [7:0]        rd_data_o,
    output logic              empty_o,
    output logic              tx_ready_o,
    output logic [ADDR_W:0]   fill_count_o,
    output logic [OVF_W-1:0]  overrun_count_o
);
    logic [2:0]        pins_s;
    logic              byte_vld;
    byte_t             byte_d;
    logic              wr_en;
    logic              rd_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    spb_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, mosi_i, sclk_i}),
        .q_o   (pins_s)
    );

    spb_spi_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[0]),
        .mosi_s     (pins_s[1]),
        .cs_n_s     (pins_s[2]),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_d)
    );

    spb_ctrl #(.ADDR_W(ADDR_W), .OVF_W(OVF_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .push_i    (byte_vld),
        .pop_i     (pop_i),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr),
        .fill_o    (fill_count_o),
        .ovf_o     (overrun_count_o),
        .empty_o   (empty_o),
        .ready_o   (tx_ready_o)
    );

    spb_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (byte_d),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/spb_checker.sv
// Temporal checks on the SPI payload buffer, bound into the top module.
module spb_checker #(
    parameter int ADDR_W = 12,
    parameter int OVF_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              pop_i,
    input logic              push,
    input logic [7:0]        rd_data,
    input logic              tx_ready,
    input logic [ADDR_W:0]   fill,
    input logic [OVF_W-1:0]  ovf
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);
    localparam logic [CNT_W-1:0] LW_C    = CNT_W'((1 << ADDR_W) / 8);

    // R1: reset leaves the store empty with no overruns.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (fill == '0 && ovf == '0));

    // R5: the fill count moves by at most one per cycle.
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (fill == $past(fill) || fill == $past(fill) + CNT_W'(1)
                      || fill + CNT_W'(1) == $past(fill)));

    // R7: never more bytes than slots.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH_C);

    // R7: a push into a full store without a pop keeps it full.
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fill == DEPTH_C && !pop_i && !clear_i) |=> fill == DEPTH_C);

    // R6: ready falls exactly when crossing the low-water mark.
    a_r6_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> fill == LW_C + CNT_W'(1));

    // R6: ready rises only on returning to the mark or on a clear.
    a_r6_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> (fill == LW_C || fill == '0));

    // R8: overrun count never decreases except on clear.
    a_r8_ovf_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ovf >= $past(ovf));

    // R9: a pop of an empty store with no write changes nothing.
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && fill == '0 && !push && !clear_i) |=> (fill == '0 && $stable(rd_data)));

    // R10: clear zeroes both counters.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (fill == '0 && ovf == '0));
endmodule

bind spi_payload_buffer spb_checker #(.ADDR_W(ADDR_W), .OVF_W(OVF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear_i),
    .pop_i    (pop_i),
    .push     (byte_vld),
    .rd_data  (rd_data_o),
    .tx_ready (tx_ready_o),
    .fill     (fill_count_o),
    .ovf      (overrun_count_o)
);

// File: tb/spi_payload_buffer_test.sv
// Scoreboard bench: the SPI driver pushes expected bytes, a monitor pops and
// compares drained bytes. Reduced depth keeps fill and overrun runs short.
module spi_payload_buffer_test;
    localparam int ADDR_W = 6;
    localparam int OVF_W  = 4;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LW     = DEPTH / 8;
    localparam int OVMAX  = (1 << OVF_W) - 1;
    localparam int HALF   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, clear = 1'b0, pop = 1'b0;
    logic [7:0]        rd_data;
    logic              empty, tx_ready;
    logic [ADDR_W:0]   fill;
    logic [OVF_W-1:0]  ovf;

    int checks = 0;
    int errors = 0;
    int model_ovf = 0;
    logic [7:0] exp_q[$];
    logic rd_seen = 1'b0;

    always #10 clk = ~clk;

    spi_payload_buffer #(.ADDR_W(ADDR_W), .OVF_W(OVF_W)) uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .cs_n_i(cs_n),
        .clear_i(clear), .pop_i(pop), .rd_data_o(rd_data), .empty_o(empty),
        .tx_ready_o(tx_ready), .fill_count_o(fill), .overrun_count_o(ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: a pop taken with data pending presents the oldest byte (R4).
    always @(posedge clk) rd_seen <= pop && (exp_q.size() > 0);
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk("R4 drain order", int'(rd_data), int'(e));
        end
    end

    // Scoreboard model of a completed byte.
    task automatic model_store(input logic [7:0] b);
        if (exp_q.size() < DEPTH) exp_q.push_back(b);
        else if (model_ovf < OVMAX) model_ovf++;
    endtask

    task automatic spi_begin();
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_end();
        @(negedge clk) cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // Send nbits of b MSB first; optionally pop in the cycle the byte lands.
    task automatic spi_bits(input logic [7:0] b, input int nbits, input bit pop_on_last);
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = b[i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            if (i == 0) model_store(b);
            if (i == 0 && pop_on_last) begin
                repeat (3) @(negedge clk);
                pop = 1'b1;
                @(negedge clk);
                pop = 1'b0;
            end else begin
                repeat (HALF) @(negedge clk);
            end
            sclk = 1'b0;
        end
    endtask

    task automatic send_bytes(input int n, input int seed);
        spi_begin();
        for (int k = 0; k < n; k++) spi_bits(8'((seed + k * 37) ^ 8'h5A), 8, 1'b0);
        spi_end();
    endtask

    task automatic drain(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) pop = 1'b1;
            @(negedge clk) pop = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 fill", int'(fill), 0);
        chk("R1 overrun", int'(ovf), 0);
        chk("R1 ready", int'(tx_ready), 1);
        chk("R1 empty", int'(empty), 1);

        // R11 clock toggles with chip select high
        for (int k = 0; k < 10; k++) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk); sclk = 1'b1;
            repeat (HALF) @(negedge clk); sclk = 0;
        end
        repeat (6) @(negedge clk);
        chk("R11 deselected clocks", int'(fill), 0);

        // R2 multi-byte transaction, MSB first
        spi_begin();
        spi_bits(8'hA5, 8, 1'b0);
        spi_bits(8'h3C, 8, 1'b0);
        spi_bits(8'h81, 8, 1'b0);
        spi_end();
        chk("R2 bytes in one transaction", int'(fill), 3);
        chk("R5 count after stores", int'(empty), 0);
        drain(3);
        chk("R5 count after drains", int'(fill), 0);

        // R3 partial byte dropped at chip select rise
        spi_begin();
        spi_bits(8'hFF, 5, 1'b0);
        spi_end();
        chk("R3 partial dropped", int'(fill), 0);
        spi_begin();
        spi_bits(8'h42, 8, 1'b0);
        spi_end();
        chk("R3 fresh byte stored", int'(fill), 1);
        drain(1);

        // R9 pop of an empty store
        held = rd_data;
        drain(1);
        chk("R9 empty pop count", int'(fill), 0);
        chk("R9 empty pop data held", int'(rd_data), int'(held));

        // R6 low-water mark boundary
        send_bytes(LW, 10);
        chk("R6 ready at mark", int'(tx_ready), 1);
        send_bytes(1, 90);
        chk("R6 ready above mark", int'(tx_ready), 0);
        drain(1);
        chk("R6 ready back at mark", int'(tx_ready), 1);

        // R5 store and pop in the same cycle
        spi_begin();
        spi_bits(8'hC3, 8, 1'b1);
        spi_end();
        chk("R5 simultaneous store and pop", int'(fill), LW);
        drain(LW);

        // R7 full store drops and counts extra bytes
        send_bytes(DEPTH, 3);
        chk("R7 fill at capacity", int'(fill), DEPTH);
        send_bytes(3, 200);
        chk("R7 fill stays at capacity", int'(fill), DEPTH);
        chk("R7 overrun counted", int'(ovf), model_ovf);
        drain(DEPTH);
        chk("R7 contents drained", int'(fill), 0);

        // R8 overrun saturation
        send_bytes(DEPTH, 7);
        send_bytes(OVMAX + 5, 11);
        chk("R8 overrun saturates", int'(ovf), OVMAX);

        // R10 clear
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
        exp_q.delete();
        model_ovf = 0;
        chk("R10 fill cleared", int'(fill), 0);
        chk("R10 overrun cleared", int'(ovf), 0);
        chk("R10 ready after clear", int'(tx_ready), 1);
        spi_begin();
        spi_bits(8'h6E, 8, 1'b0);
        spi_end();
        chk("R10 store after clear", int'(fill), 1);
        drain(1);
        chk("R10 drained after clear", int'(empty), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule